// File: doc/BRIEF.md
# Effective-Address Extension Word Decoder

This block turns an operand specifier, made of a 3-bit mode field, a 3-bit register field and a 2-bit operand size, into a resolved operand description. Some specifiers need extra data. For those, the block pulls zero, one or two 16-bit extension words from a ready/valid word stream. It then reports the addressing form, the base register, any index-register descriptor, a 32-bit displacement or immediate value, and how many words it used.

An instruction decoder raises `start_i` with the specifier while the block is idle. The block then fetches exactly as many words as that specifier needs. It ends with a one-cycle `done_o` pulse, and the results stay on the outputs until the next `done_o`. A new request may be issued in the same cycle that `done_o` is shown. Computing the actual memory address is left to the consumer.

Top module: `ea_ext_decoder`

## Requirements
- R1: Modes 0 to 4 use no extension words. `done_o` rises in the cycle after the start is accepted. `ea_mode_o` equals the mode field (codes 0 to 4), and `ea_reg_o` carries the register field.
- R2: Mode 5 uses one word. `value_o` is that word sign-extended from bit 15, `ea_mode_o` is 5, and `ea_reg_o` is the register field.
- R3: Mode 6 (code 6) and mode 7 with register 3 (code 10) each use one index word. `index_o` is word bits 15:11: bit 4 means address register, bits 3:1 are the index register number, and bit 0 means a long index. `value_o` is word bits 7:0 sign-extended from bit 7. For all other codes, `index_o` is 0.
- R4: Mode 7 with register 0 (code 7, short absolute) and with register 2 (code 9, program-counter displacement) each use one word, sign-extended from bit 15.
- R5: Mode 7 with register 1 (code 8, long absolute) uses two words. The first word forms bits 31:16 and the second forms bits 15:0.
- R6: Mode 7 with register 4 (code 11) is immediate. Size 0 uses one word and yields its low byte, zero-extended. Size 1 uses one word, zero-extended. Size 2 or 3 uses two words, high word first.
- R7: Mode 7 with register 5, 6 or 7 yields code 15. `err_o` is 1, no word is used, and `done_o` follows in the next cycle. `err_o` is 0 for every other specifier.
- R8: `word_ready_o` is high only while words are still owed. A word is taken only in a cycle where both `word_valid_i` and `word_ready_o` are high. Stall cycles, with valid low, are waited out without loss.
- R9: `done_o` is a one-cycle pulse that appears in the cycle after the last word is taken. `words_o` gives the number of words used. `value_o`, `words_o` and the other results change only together with `done_o`.
- R10: While a request is still fetching words, `start_i` and new specifier inputs are ignored.
- R11: While `rst_ni` is low, all outputs are 0 and `word_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a decode; taken only while idle |
| mode_i | input | 3 | Mode field |
| reg_i | input | 3 | Register field |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| word_i | input | 16 | Extension word |
| word_valid_i | input | 1 | Extension word present |
| word_ready_o | output | 1 | Block will take the offered word |
| done_o | output | 1 | One-cycle completion pulse |
| ea_mode_o | output | 4 | Resolved addressing code |
| ea_reg_o | output | 3 | Base register, 0 for mode 7 |
| index_o | output | 5 | Index descriptor (R3) |
| value_o | output | 32 | Displacement, address or immediate |
| words_o | output | 2 | Extension words used |
| err_o | output | 1 | Invalid specifier |

## Verification
Two events can fall in the same cycle: the completion pulse of one request and the acceptance of the next `start_i`. This becomes a real hazard when the new request needs zero words and finishes in the very next cycle. The bench always issues the next request in the cycle where `done_o` is shown. It also keeps `word_valid_i` high with a stray word during those idle cycles, and scrambles `start_i` and the specifier inputs while a fetch is still in progress. Each result is judged on three points: the number of words the bench saw taken, `words_o`, and the decoded fields, all compared against values the bench computes from the original specifier.

// File: rtl/ead_pkg.sv
package ead_pkg;
  typedef enum logic [3:0] {
    EA_DREG    = 4'd0,
    EA_AREG    = 4'd1,
    EA_IND     = 4'd2,
    EA_POSTINC = 4'd3,
    EA_PREDEC  = 4'd4,
    EA_DISP    = 4'd5,
    EA_INDEX   = 4'd6,
    EA_ABS_S   = 4'd7,
    EA_ABS_L   = 4'd8,
    EA_PC_DISP = 4'd9,
    EA_PC_IDX  = 4'd10,
    EA_IMM     = 4'd11,
    EA_BAD     = 4'd15
  } ea_code_e;

  function automatic ea_code_e ea_classify(logic [2:0] m, logic [2:0] r);
    ea_code_e c;
    if (m != 3'd7) begin
      c = ea_code_e'({1'b0, m});
    end else begin
      case (r)
        3'd0:    c = EA_ABS_S;
        3'd1:    c = EA_ABS_L;
        3'd2:    c = EA_PC_DISP;
        3'd3:    c = EA_PC_IDX;
        3'd4:    c = EA_IMM;
        default: c = EA_BAD;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/ead_len.sv
module ead_len
  import ead_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [2:0] reg_i,
  input  logic [1:0] size_i,
  output ea_code_e   code_o,
  output logic [1:0] need_o
);
  always_comb begin
    code_o = ea_classify(mode_i, reg_i);
    case (code_o)
      EA_DREG, EA_AREG, EA_IND, EA_POSTINC, EA_PREDEC, EA_BAD: need_o = 2'd0;
      EA_ABS_L: need_o = 2'd2;
      EA_IMM:   need_o = size_i[1] ? 2'd2 : 2'd1;
      default:  need_o = 2'd1;
    endcase
  end
endmodule

// File: rtl/ead_pack.sv
module ead_pack
  import ead_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 5,
  parameter int DISP_W = 8
) (
  input  ea_code_e                  code_i,
  input  logic [1:0]                size_i,
  input  logic [WORD_W-1:0]         w_hi_i,
  input  logic [WORD_W-1:0]         w_cur_i,
  output logic [2*WORD_W-1:0]       val_o,
  output logic [IDX_W-1:0]          idx_o
);
  localparam int VAL_W = 2 * WORD_W;

  always_comb begin
    val_o = '0;
    idx_o = '0;
    case (code_i)
      EA_DISP, EA_ABS_S, EA_PC_DISP:
        val_o = {{WORD_W{w_cur_i[WORD_W-1]}}, w_cur_i};
      EA_INDEX, EA_PC_IDX: begin
        val_o = {{(VAL_W-DISP_W){w_cur_i[DISP_W-1]}}, w_cur_i[DISP_W-1:0]};
        idx_o = w_cur_i[WORD_W-1 -: IDX_W];
      end
      EA_ABS_L:
        val_o = {w_hi_i, w_cur_i};
      EA_IMM: begin
        if (size_i[1])           val_o = {w_hi_i, w_cur_i};
        else if (size_i == 2'd0) val_o = {{(VAL_W-DISP_W){1'b0}}, w_cur_i[DISP_W-1:0]};
        else                     val_o = {{WORD_W{1'b0}}, w_cur_i};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_ext_decoder.sv
module ea_ext_decoder
  import ead_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [2:0]           mode_i,
  input  logic [2:0]           reg_i,
  input  logic [1:0]           size_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic                 word_valid_i,
  output logic                 word_ready_o,
  output logic                 done_o,
  output logic [3:0]           ea_mode_o,
  output logic [2:0]           ea_reg_o,
  output logic [4:0]           index_o,
  output logic [2*WORD_W-1:0]  value_o,
  output logic [1:0]           words_o,
  output logic                 err_o
);
  localparam int VAL_W = 2 * WORD_W;
  localparam int IDX_W = 5;

  typedef enum logic {ST_IDLE, ST_FETCH} state_e;

  state_e            state_q;
  ea_code_e          code_q;
  logic [1:0]        size_q;
  logic [2:0]        reg_q;
  logic [1:0]        need_q, cnt_q;
  logic [WORD_W-1:0] hi_q;

  ea_code_e          new_code;
  logic [1:0]        new_need;
  logic [VAL_W-1:0]  pk_val;
  logic [IDX_W-1:0]  pk_idx;
  logic              take, last;

  ead_len u_len (
    .mode_i (mode_i),
    .reg_i  (reg_i),
    .size_i (size_i),
    .code_o (new_code),
    .need_o (new_need)
  );

  ead_pack #(.WORD_W(WORD_W), .IDX_W(IDX_W), .DISP_W(8)) u_pack (
    .code_i  (code_q),
    .size_i  (size_q),
    .w_hi_i  (hi_q),
    .w_cur_i (word_i),
    .val_o   (pk_val),
    .idx_o   (pk_idx)
  );

  assign word_ready_o = (state_q == ST_FETCH);
  assign take         = word_ready_o && word_valid_i;
  assign last         = take && ((cnt_q + 2'd1) == need_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      code_q    <= EA_DREG;
      size_q    <= '0;
      reg_q     <= '0;
      need_q    <= '0;
      cnt_q     <= '0;
      hi_q      <= '0;
      done_o    <= 1'b0;
      ea_mode_o <= '0;
      ea_reg_o  <= '0;
      index_o   <= '0;
      value_o   <= '0;
      words_o   <= '0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          code_q <= new_code;
          size_q <= size_i;
          reg_q  <= (mode_i == 3'd7) ? 3'd0 : reg_i;
          need_q <= new_need;
          cnt_q  <= '0;
          if (new_need == 2'd0) begin
            done_o    <= 1'b1;
            ea_mode_o <= new_code;
            ea_reg_o  <= (mode_i == 3'd7) ? 3'd0 : reg_i;
            index_o   <= '0;
            value_o   <= '0;
            words_o   <= '0;
            err_o     <= (new_code == EA_BAD);
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (take) begin
          if (last) begin
            state_q   <= ST_IDLE;
            done_o    <= 1'b1;
            ea_mode_o <= code_q;
            ea_reg_o  <= reg_q;
            index_o   <= pk_idx;
            value_o   <= pk_val;
            words_o   <= need_q;
            err_o     <= 1'b0;
          end else begin
            hi_q  <= word_i;
            cnt_q <= cnt_q + 2'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ead_checker.sv
module ead_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        word_ready_o,
  input logic        done_o,
  input logic [3:0]  ea_mode_o,
  input logic [4:0]  index_o,
  input logic [31:0] value_o,
  input logic [1:0]  words_o,
  input logic        err_o
);
  AST_DONE_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !word_ready_o); // R9
  AST_READY_DROP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(word_ready_o) |-> done_o); // R8
  AST_BAD_NO_WORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (words_o == 2'd0 && ea_mode_o == 4'hF)); // R7
  AST_INDEX_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ea_mode_o != 4'd6 && ea_mode_o != 4'd10) |-> (index_o == 5'd0)); // R3
  AST_VALUE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(value_o) |-> done_o); // R9
  AST_WORDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(words_o) |-> done_o); // R9
endmodule

bind ea_ext_decoder ead_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_ready_o (word_ready_o),
  .done_o       (done_o),
  .ea_mode_o    (ea_mode_o),
  .index_o      (index_o),
  .value_o      (value_o),
  .words_o      (words_o),
  .err_o        (err_o)
);

// File: tb/sim_ea_ext_decoder.sv
`timescale 1ns/1ps
module sim_ea_ext_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [2:0]  reg_i = '0;
  logic [1:0]  size_i = '0;
  logic [15:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o, done_o, err_o;
  logic [3:0]  ea_mode_o;
  logic [2:0]  ea_reg_o;
  logic [4:0]  index_o;
  logic [31:0] value_o;
  logic [1:0]  words_o;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  ea_ext_decoder u0 (.*);

  function automatic int exp_words(logic [2:0] m, logic [2:0] r, logic [1:0] s);
    if (m < 3'd5) return 0;
    if (m != 3'd7) return 1;
    case (r)
      3'd1: return 2;
      3'd4: return s[1] ? 2 : 1;
      3'd0, 3'd2, 3'd3: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] exp_code(logic [2:0] m, logic [2:0] r);
    if (m != 3'd7) return {1'b0, m};
    if (r > 3'd4) return 4'hF;
    return 4'd7 + {1'b0, r};
  endfunction

  function automatic logic [31:0] exp_value(logic [3:0] c, logic [1:0] s,
                                            logic [15:0] a, logic [15:0] b);
    logic [15:0] one;
    one = a;
    case (c)
      4'd5, 4'd7, 4'd9: return {{16{one[15]}}, one};
      4'd6, 4'd10:      return {{24{one[7]}}, one[7:0]};
      4'd8:             return {a, b};
      4'd11: begin
        if (s[1]) return {a, b};
        if (s == 2'd0) return {24'd0, one[7:0]};
        return {16'd0, one};
      end
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_for(logic [3:0] c);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4: return "R1";
      4'd5:          return "R2";
      4'd6, 4'd10:   return "R3";
      4'd7, 4'd9:    return "R4";
      4'd8:          return "R5";
      4'd11:         return "R6";
      default:       return "R7";
    endcase
  endfunction

  // Called at a negedge; returns at the negedge where done_o is seen.
  task automatic req(logic [2:0] m, logic [2:0] r, logic [1:0] s,
                     logic [15:0] a, logic [15:0] b, bit stall);
    int n, taken, waited;
    logic [3:0] c;
    string t;
    n = exp_words(m, r, s);
    c = exp_code(m, r);
    t = tag_for(c);
    start_i = 1'b1; mode_i = m; reg_i = r; size_i = s;
    word_valid_i = 1'b1; word_i = 16'hDEAD;  // idle offer, must not be taken (R8)
    @(negedge clk_i);
    taken = 0; waited = 0;
    while (!done_o && waited < 40) begin
      start_i = $urandom_range(0, 1);      // R10: ignored while fetching
      mode_i  = 3'($urandom); reg_i = 3'($urandom); size_i = 2'($urandom);
      word_valid_i = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
      word_i = (taken == 0) ? a : b;
      if (word_valid_i && word_ready_o) taken++;
      waited++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    word_valid_i = 1'b1; word_i = 16'hBEEF;
    chk("R9 done", {31'd0, done_o}, 32'd1);
    chk("R8 taken", taken, n);
    chk("R9 words_o", {30'd0, words_o}, n);
    chk("R8 ready low at done", {31'd0, word_ready_o}, 32'd0);
    chk({t, " code"}, {28'd0, ea_mode_o}, {28'd0, c});
    chk({t, " value"}, value_o, exp_value(c, s, a, b));
    chk("R3 index", {27'd0, index_o},
        (c == 4'd6 || c == 4'd10) ? {27'd0, a[15:11]} : 32'd0);
    chk("R1 reg", {29'd0, ea_reg_o}, (m == 3'd7) ? 32'd0 : {29'd0, r});
    chk("R7 err", {31'd0, err_o}, {31'd0, c == 4'hF});
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk_i);
    chk("R11 ready", {31'd0, word_ready_o}, 32'd0);
    chk("R11 done", {31'd0, done_o}, 32'd0);
    chk("R11 value", value_o, 32'd0);
    chk("R11 mode", {28'd0, ea_mode_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // directed corners
    req(3'd0, 3'd5, 2'd0, 16'h0, 16'h0, 0);
    req(3'd4, 3'd7, 2'd2, 16'h0, 16'h0, 0);
    req(3'd5, 3'd2, 2'd1, 16'h8000, 16'h0, 1);
    req(3'd6, 3'd1, 2'd1, 16'hF880, 16'h0, 1);
    req(3'd7, 3'd3, 2'd0, 16'h307F, 16'h0, 0);
    req(3'd7, 3'd0, 2'd1, 16'hFFFE, 16'h0, 0);
    req(3'd7, 3'd2, 2'd1, 16'h7FFF, 16'h0, 1);
    req(3'd7, 3'd1, 2'd2, 16'h1234, 16'hABCD, 1);
    req(3'd7, 3'd4, 2'd0, 16'hFFAA, 16'h0, 0);
    req(3'd7, 3'd4, 2'd1, 16'h8001, 16'h0, 0);
    req(3'd7, 3'd4, 2'd3, 16'h8765, 16'h4321, 1);
    req(3'd7, 3'd7, 2'd0, 16'h0, 16'h0, 0);
    req(3'd7, 3'd5, 2'd1, 16'h0, 16'h0, 0);
    // R9: results hold across idle cycles with a stray word offered
    repeat (3) @(negedge clk_i);
    chk("R9 hold err", {31'd0, err_o}, 32'd1);
    chk("R8 idle ready", {31'd0, word_ready_o}, 32'd0);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk_i);
      req(3'($urandom), 3'($urandom), 2'($urandom), 16'($urandom), 16'($urandom),
          bit'($urandom_range(0, 1)));
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule